// File: doc/BRIEF.md
# Video Coprocessor Command Mailbox

This block is the register-mapped meeting point between a host processor and an embedded video-processing core. The host writes the address of a prepared command into a pending-command register. On a frame-sync event the mailbox copies that pointer into the active-command register, presents it to the core and raises a one-cycle start strobe. The pending register keeps its value, so an unchanged pointer is presented again on every frame until the host replaces it or writes zero ("no command").

The sync source can be selected. In hardware mode a vsync strobe from the timing generator triggers promotion. In software-command mode the host's own write of a pending pointer triggers it. A hold mode lets no sync through at all; it is used while the core boots.

Around this handoff sits the boot handshake. A full software reset runs for a fixed count, clears both pointers and every startup bit, and then reports reset-done. A core-only reset cycles the core alone. An idle-authorisation bit and a fetch-enable bit start the core. A core-info word reports ready, processing and queue-initialisation flags. The bus uses word addresses: word index = byte offset / 4.

Top module: `vcp_mailbox`

## Requirements
- R1: After the synchronous reset, every word index 0..10 reads zero, and cmd_ptr_o, cmd_start_o, core_rst_o, core_fetch_en_o and core_idle_auth_o are all low.
- R2: Writing word 4 (offset 0x10) with bit 0 set is a full reset. At that edge both command pointers, idle authorisation, fetch enable, the processing flag and reset-done (word 5 bit 0) are cleared. core_rst_o is then high for exactly RST_CYCLES cycles, after which word 5 bit 0 reads 1. All bus writes are ignored while a full reset is counting.
- R3: Writing word 4 with only bit 1 set is a core-only reset. core_rst_o is high for RST_CYCLES cycles and the processing flag clears. Both pointers, idle authorisation, fetch enable and reset-done keep their values.
- R4: Word 5 bit 2 is a read/write idle-authorisation bit that drives core_idle_auth_o. Word 6 bit 1 is a read/write fetch-enable bit that drives core_fetch_en_o. The other bits of these words read 0, except word 5 bit 0 (reset-done).
- R5: The sync mode is word 10 (offset 0x28), bits 1:0, reading back as written: 0 = hardware, 1 = software command, 3 = hold. In mode 0, a hw_vsync_i strobe while the pending pointer (word 8) is nonzero copies it into the current pointer (word 9, cmd_ptr_o) at that edge. cmd_start_o is high for that one cycle, and the pending pointer is not cleared.
- R6: A sync event with a pending pointer of zero changes nothing. A hw_vsync_i strobe in any mode other than 0 is ignored.
- R7: In mode 1, a write of a nonzero value to word 8 stores it and, at the same edge, promotes it to the current pointer with a start strobe. A write of zero only stores it.
- R8: Word 3 (core info) reads bit 15 = ready (fetch enabled, not processing, core not in reset), bit 14 = processing (set on promotion, cleared by core_done_i or a core/full reset), and bit 13 = core_initq_i. All other bits read 0.
- R9: Word 9 is read-only, and writes to it are ignored. Words 0, 1, 2 and 7 read zero whatever is written to them.
- R10: bus_rdata is registered. It is valid in the cycle after bus_rd_en and shows the state before that clock edge, including a write made in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_vsync_i | input | 1 | One-cycle hardware frame-sync strobe |
| core_done_i | input | 1 | Core finished the active command |
| core_initq_i | input | 1 | Core is initialising its queues |
| cmd_ptr_o | output | 32 | Active command pointer |
| cmd_start_o | output | 1 | One-cycle strobe on promotion |
| core_rst_o | output | 1 | Reset to the embedded core |
| core_fetch_en_o | output | 1 | Instruction fetch enable |
| core_idle_auth_o | output | 1 | Idle mode authorisation |

## Verification
On every cycle, the assertions check four things. The active pointer moves only on an accepted sync or a full reset. A start strobe never carries a zero pointer. The pending pointer stays put unless it is written. A full reset always drops reset-done and holds the core in reset. Other behaviour needs whole scenarios from the bench: the exact length of the reset window, the fact that a core-only reset leaves everything else alone, and ignored writes during the countdown. The same goes for the interleaving of mode changes, pointer writes, vsync strobes and completions in the random phase, where a bench model predicts the pointer, strobe and core-info flags.

// File: rtl/vcp_mbox_pkg.sv
package vcp_mbox_pkg;

  localparam int unsigned DW = 32;

  // word indices (byte offset / 4); the host software depends on these
  localparam int unsigned W_IRQ_CORE  = 0;
  localparam int unsigned W_HOST_INFO = 1;
  localparam int unsigned W_IRQ_HOST  = 2;
  localparam int unsigned W_CORE_INFO = 3;
  localparam int unsigned W_SWRST     = 4;
  localparam int unsigned W_BOOT1     = 5;
  localparam int unsigned W_BOOT2     = 6;
  localparam int unsigned W_GP_STAT   = 7;
  localparam int unsigned W_NEXT      = 8;
  localparam int unsigned W_CUR       = 9;
  localparam int unsigned W_SYNC      = 10;

  // bit positions
  localparam int unsigned B_FULL_RST  = 0;
  localparam int unsigned B_CORE_RST  = 1;
  localparam int unsigned B_RST_DONE  = 0;
  localparam int unsigned B_IDLE_AUTH = 2;
  localparam int unsigned B_FETCH     = 1;
  localparam int unsigned B_READY     = 15;
  localparam int unsigned B_PROC      = 14;
  localparam int unsigned B_INITQ     = 13;

  typedef enum logic [1:0] {
    SYNC_HW   = 2'd0,
    SYNC_SWC  = 2'd1,
    SYNC_RSV  = 2'd2,
    SYNC_HOLD = 2'd3
  } sync_mode_e;

endpackage

// File: rtl/vcp_mbox_rstseq.sv
module vcp_mbox_rstseq #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic full_req,
  input  logic core_req,
  output logic full_busy,
  output logic core_rst,
  output logic rst_done
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          kind_full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      kind_full_q <= 1'b0;
      rst_done    <= 1'b0;
    end else if (full_req) begin
      cnt_q       <= CW'(RST_CYCLES);
      kind_full_q <= 1'b1;
      rst_done    <= 1'b0;
    end else if (core_req && cnt_q == '0) begin
      cnt_q       <= CW'(RST_CYCLES);
      kind_full_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1) && kind_full_q) rst_done <= 1'b1;
    end
  end

  assign core_rst  = (cnt_q != '0);
  assign full_busy = (cnt_q != '0) && kind_full_q;

  a_r2_full_clears_done: assert property (@(posedge clk) disable iff (rst)
    full_req |=> (!rst_done && core_rst));

  a_r3_core_keeps_done: assert property (@(posedge clk) disable iff (rst)
    (core_req && !full_req && !core_rst) |=> (rst_done == $past(rst_done)));

endmodule

// File: rtl/vcp_mbox_cmd.sv
module vcp_mbox_cmd
  import vcp_mbox_pkg::*;
#(
  parameter int unsigned PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             core_clear,
  input  logic             next_wr,
  input  logic [PTR_W-1:0] wdata,
  input  logic             hw_sync,
  input  sync_mode_e       mode,
  input  logic             core_done,
  output logic [PTR_W-1:0] next_q,
  output logic [PTR_W-1:0] cur_q,
  output logic             busy_q,
  output logic             start_q
);
  logic             hw_take, sw_take, promote;
  logic [PTR_W-1:0] cand;

  always_comb begin
    hw_take = hw_sync && (mode == SYNC_HW);
    sw_take = next_wr && (mode == SYNC_SWC);
    cand    = sw_take ? wdata : next_q;
    promote = (hw_take || sw_take) && (cand != '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      next_q  <= '0;
      cur_q   <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= promote;
      if (next_wr) next_q <= wdata;
      if (promote) begin
        cur_q  <= cand;
        busy_q <= 1'b1;
      end else if (core_done || core_clear) begin
        busy_q <= 1'b0;
      end
    end
  end

  a_r6_cur_hold: assert property (@(posedge clk) disable iff (rst)
    (!(hw_sync && mode == SYNC_HW) && !(next_wr && mode == SYNC_SWC) && !clear)
      |=> $stable(cur_q));

  a_r5_start_nonzero: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (cur_q != '0));

  a_r5_next_kept: assert property (@(posedge clk) disable iff (rst)
    (!next_wr && !clear) |=> $stable(next_q));

endmodule

// File: rtl/vcp_mbox_regs.sv
module vcp_mbox_regs
  import vcp_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              full_busy,
  input  logic              core_rst,
  input  logic              rst_done,
  input  logic [DW-1:0]     next_q,
  input  logic [DW-1:0]     cur_q,
  input  logic              busy,
  input  logic              initq,
  output logic              full_req,
  output logic              core_req,
  output logic              next_wr,
  output sync_mode_e        mode_q,
  output logic              idle_auth_q,
  output logic              fetch_en_q
);
  logic          wr_ok;
  logic [DW-1:0] rd_mux;

  assign wr_ok    = wr_en && !full_busy;
  assign full_req = wr_ok && (addr == ADDR_W'(W_SWRST)) && wdata[B_FULL_RST];
  assign core_req = wr_ok && (addr == ADDR_W'(W_SWRST)) && wdata[B_CORE_RST]
                    && !wdata[B_FULL_RST];
  assign next_wr  = wr_ok && (addr == ADDR_W'(W_NEXT));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= SYNC_HW;
      idle_auth_q <= 1'b0;
      fetch_en_q  <= 1'b0;
    end else if (full_req) begin
      idle_auth_q <= 1'b0;
      fetch_en_q  <= 1'b0;
    end else if (wr_ok) begin
      if (addr == ADDR_W'(W_BOOT1)) idle_auth_q <= wdata[B_IDLE_AUTH];
      if (addr == ADDR_W'(W_BOOT2)) fetch_en_q  <= wdata[B_FETCH];
      if (addr == ADDR_W'(W_SYNC))  mode_q      <= sync_mode_e'(wdata[1:0]);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(W_CORE_INFO)) begin
      rd_mux[B_READY] = fetch_en_q && !busy && !core_rst;
      rd_mux[B_PROC]  = busy;
      rd_mux[B_INITQ] = initq;
    end else if (addr == ADDR_W'(W_BOOT1)) begin
      rd_mux[B_RST_DONE]  = rst_done;
      rd_mux[B_IDLE_AUTH] = idle_auth_q;
    end else if (addr == ADDR_W'(W_BOOT2)) begin
      rd_mux[B_FETCH] = fetch_en_q;
    end else if (addr == ADDR_W'(W_NEXT)) begin
      rd_mux = next_q;
    end else if (addr == ADDR_W'(W_CUR)) begin
      rd_mux = cur_q;
    end else if (addr == ADDR_W'(W_SYNC)) begin
      rd_mux[1:0] = mode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  a_r4_fetch_write: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && addr == ADDR_W'(W_BOOT2)) |=> (fetch_en_q == $past(wdata[B_FETCH])));

  a_r2_writes_blocked: assert property (@(posedge clk) disable iff (rst)
    (full_busy && !wr_ok) |=> ($stable(mode_q) && $stable(idle_auth_q)));

endmodule

// File: rtl/vcp_mailbox.sv
module vcp_mailbox
  import vcp_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_vsync_i,
  input  logic              core_done_i,
  input  logic              core_initq_i,
  output logic [31:0]       cmd_ptr_o,
  output logic              cmd_start_o,
  output logic              core_rst_o,
  output logic              core_fetch_en_o,
  output logic              core_idle_auth_o
);
  logic          full_req, core_req, next_wr, full_busy, core_rst, rst_done;
  logic          busy;
  logic [DW-1:0] next_q, cur_q;
  sync_mode_e    mode_q;

  vcp_mbox_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .full_busy(full_busy), .core_rst(core_rst), .rst_done(rst_done),
    .next_q(next_q), .cur_q(cur_q), .busy(busy), .initq(core_initq_i),
    .full_req(full_req), .core_req(core_req), .next_wr(next_wr),
    .mode_q(mode_q), .idle_auth_q(core_idle_auth_o), .fetch_en_q(core_fetch_en_o)
  );

  vcp_mbox_rstseq #(.RST_CYCLES(RST_CYCLES)) rstseq_i (
    .clk(clk), .rst(rst), .full_req(full_req), .core_req(core_req),
    .full_busy(full_busy), .core_rst(core_rst), .rst_done(rst_done)
  );

  vcp_mbox_cmd #(.PTR_W(DW)) cmd_i (
    .clk(clk), .rst(rst), .clear(full_req), .core_clear(core_req),
    .next_wr(next_wr), .wdata(bus_wdata), .hw_sync(hw_vsync_i),
    .mode(mode_q), .core_done(core_done_i), .next_q(next_q),
    .cur_q(cur_q), .busy_q(busy), .start_q(cmd_start_o)
  );

  assign cmd_ptr_o  = cur_q;
  assign core_rst_o = core_rst;

  a_r2_full_zeroes_ptr: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && !full_busy && bus_addr == ADDR_W'(W_SWRST) && bus_wdata[B_FULL_RST])
      |=> (cmd_ptr_o == '0 && !core_fetch_en_o && !cmd_start_o));

endmodule

// File: tb/vcp_mailbox_tb_top.sv
`timescale 1ns/1ps
module vcp_mailbox_tb_top;
  localparam int unsigned AW = 4;
  localparam int unsigned NRST = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic          hw_vsync_i = 1'b0, core_done_i = 1'b0, core_initq_i = 1'b0;
  logic [31:0]   cmd_ptr_o;
  logic          cmd_start_o, core_rst_o, core_fetch_en_o, core_idle_auth_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // bench model
  logic [31:0] m_next = 0, m_cur = 0;
  logic [1:0]  m_mode = 0;
  logic        m_busy = 0, m_fetch = 0, m_start = 0;

  always #4 clk = ~clk;

  vcp_mailbox #(.ADDR_W(AW), .RST_CYCLES(NRST)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_vsync();
    @(negedge clk); hw_vsync_i = 1'b1;
    @(negedge clk); hw_vsync_i = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done_i = 1'b1;
    @(negedge clk); core_done_i = 1'b0;
  endtask

  function automatic logic [31:0] exp_info();
    return {16'h0, m_fetch && !m_busy, m_busy, core_initq_i, 13'h0};
  endfunction

  task automatic model_promote(input logic [31:0] v);
    m_start = 1'b0;
    if (v != 0) begin m_cur = v; m_busy = 1'b1; m_start = 1'b1; end
  endtask

  task automatic count_rst(output int n);
    n = 0;
    while (core_rst_o && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 outputs", {27'h0, cmd_start_o, core_rst_o, core_fetch_en_o, core_idle_auth_o, 1'b0}, 0);
    chk("R1 ptr", cmd_ptr_o, 0);
    for (int i = 0; i <= 10; i++) begin rd(i, d); chk("R1 word", d, 0); end

    // R2: full reset and boot
    wr(8, 32'h1111_0000);
    wr(4, 32'h1);
    count_rst(n);
    chk("R2 reset length", n, NRST);
    rd(5, d); chk("R2 reset done", d, 32'h1);
    rd(8, d); chk("R2 next cleared", d, 0);

    // R2: writes ignored while counting
    wr(4, 32'h1);
    wr(6, 32'h2);
    wr(8, 32'h55);
    count_rst(n);
    rd(6, d); chk("R2 fetch write ignored", d, 0);
    rd(8, d); chk("R2 next write ignored", d, 0);

    // R4: startup bits
    wr(5, 32'hFFFF_FFFF);
    rd(5, d); chk("R4 idle auth readback", d, 32'h5);
    chk("R4 idle auth pin", core_idle_auth_o, 1);
    wr(6, 32'hFFFF_FFFF);
    rd(6, d); chk("R4 fetch readback", d, 32'h2);
    chk("R4 fetch pin", core_fetch_en_o, 1);
    m_fetch = 1;

    // R5/R6: hold mode during boot, then hardware sync
    wr(10, 32'h3);
    rd(10, d); chk("R5 mode readback", d, 3);
    wr(8, 32'hA000_0040);
    m_next = 32'hA000_0040;
    pulse_vsync();
    chk("R6 vsync ignored in hold", cmd_ptr_o, 0);
    wr(10, 32'h0);
    pulse_vsync();
    chk("R5 promoted", cmd_ptr_o, 32'hA000_0040);
    chk("R5 start strobe", cmd_start_o, 1);
    @(negedge clk);
    chk("R5 strobe one cycle", cmd_start_o, 0);
    rd(8, d); chk("R5 next kept", d, 32'hA000_0040);
    m_cur = 32'hA000_0040; m_busy = 1;

    // R8: core info
    core_initq_i = 1'b1;
    rd(3, d); chk("R8 info busy", d, exp_info());
    core_initq_i = 1'b0;
    pulse_done(); m_busy = 0;
    rd(3, d); chk("R8 info ready", d, exp_info());

    // R6: zero pending does nothing
    wr(8, 0); m_next = 0;
    pulse_vsync();
    chk("R6 zero next no promote", cmd_ptr_o, 32'hA000_0040);
    chk("R6 zero next no strobe", cmd_start_o, 0);

    // R7: software command mode
    wr(10, 32'h1); m_mode = 1;
    wr(8, 32'hB000_0080);
    chk("R7 sw promote", cmd_ptr_o, 32'hB000_0080);
    chk("R7 sw strobe", cmd_start_o, 1);
    m_cur = 32'hB000_0080; m_next = 32'hB000_0080; m_busy = 1;
    pulse_vsync();
    chk("R6 vsync ignored in mode 1", cmd_ptr_o, 32'hB000_0080);
    wr(8, 0); m_next = 0;
    chk("R7 zero write no promote", cmd_ptr_o, 32'hB000_0080);

    // R10: read right after write
    wr(8, 32'h1234_5678); m_cur = 32'h1234_5678; m_next = m_cur;
    rd(8, d); chk("R10 read after write", d, 32'h1234_5678);

    // R9: read-only / unused words
    wr(9, 32'hDEAD_BEEF);
    rd(9, d); chk("R9 current read only", d, 32'h1234_5678);
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R9 word0 zero", d, 0);
    wr(7, 32'hFFFF_FFFF); rd(7, d); chk("R9 word7 zero", d, 0);

    // R3: core-only reset
    wr(4, 32'h2);
    count_rst(n);
    chk("R3 core reset length", n, NRST);
    m_busy = 0;
    rd(9, d); chk("R3 current kept", d, 32'h1234_5678);
    rd(8, d); chk("R3 next kept", d, 32'h1234_5678);
    rd(5, d); chk("R3 boot bits kept", d, 32'h5);
    rd(3, d); chk("R3 processing cleared", d, exp_info());

    // random phase (R5 R6 R7 R8)
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom_range(0, 4));
      m_start = 0;
      case (op)
        0: begin
          v = ($urandom_range(0, 3) == 0) ? 32'h0 : ($urandom | 32'h1);
          wr(8, v);
          if (m_mode == 1) model_promote(v);
          m_next = v;
        end
        1: begin
          pulse_vsync();
          if (m_mode == 0) model_promote(m_next);
        end
        2: begin
          pulse_done();
          m_busy = 0;
        end
        3: begin
          v = {30'h0, 2'($urandom_range(0, 3))};
          wr(10, v); m_mode = v[1:0];
        end
        default: begin
          rd(3, d); chk("R8 random info", d, exp_info());
        end
      endcase
      chk("R5 random ptr", cmd_ptr_o, m_cur);
      chk("R7 random strobe", cmd_start_o, m_start);
    end

    // R2: full reset clears pointers and boot bits at the end
    wr(4, 32'h1);
    chk("R2 ptr cleared", cmd_ptr_o, 0);
    chk("R2 fetch cleared", core_fetch_en_o, 0);
    count_rst(n);
    rd(5, d); chk("R2 done after reboot", d, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

endmodule